// File: doc/BRIEF.md
# Packed Decimal Sign-Magnitude / Ten's-Complement Converter

This block converts a 32-bit packed decimal word between two forms. The first is sign-magnitude: seven BCD digits, most significant digit in the top nibble, followed by a sign code in the lowest nibble. The second is ten's complement: eight BCD digits and no sign nibble. In that form a leading digit of 0 to 4 marks a positive value and 5 to 9 marks a negative one. The ten's-complement range is therefore −50,000,000 to +49,999,999, so it is not symmetric.

A single `mode` bit picks the direction. The operand is captured with a one-cycle `start` pulse. The block then walks the eight digit positions, one per clock and least significant first. A single decimal borrow bit is carried between positions. Before converting, the block checks every nibble. It accepts every common sign code on input and emits only the two canonical codes. It reports a magnitude that does not fit in seven digits, and it reports malformed input.

Top module: `pdec_tc_conv`

## Requirements
- R1: After reset, `done`, `busy`, `invalid` and `overflow` are 0 and `dout` is 0.
- R2: With `mode`=0 and a positive sign code (hex A, C, E or F, where F means unsigned), `dout` is a 0 digit followed by the seven input digits. Example: 0000127C gives 00000127.
- R3: With `mode`=0 and a negative sign code (hex B or D), `dout` is 100,000,000 minus the magnitude, as eight BCD digits. Example: 1234567D gives 98765433, and 0000001B gives 99999999.
- R4: Zero has a single form. Sign-magnitude 0000000D (negative zero) gives 00000000, and ten's-complement 00000000 gives 0000000C.
- R5: With `mode`=1, a word whose top digit is 0–4 gives its low seven digits with sign C. A word whose top digit is 5–9 gives the low seven digits of (100,000,000 − value) with sign D. Example: 99999999 gives 0000001D.
- R6: Every valid sign-magnitude result carries sign nibble hex C (non-negative) or hex D (negative), in bits 3:0, whatever sign code the value arrived with.
- R7: With `mode`=1, `overflow` is 1 when the magnitude exceeds 9,999,999, and `dout` then holds the truncated low seven digits with the correct sign. Example: 12345678 gives 2345678C, and 50000000 gives 0000000D. With `mode`=0, `overflow` is always 0.
- R8: Input is invalid if any digit nibble exceeds 9, or if, with `mode`=0, the sign nibble (bits 3:0) is below hex A. For invalid input, `invalid`=1, `dout`=0 and `overflow`=0.
- R9: The `start` is sampled on a clock edge when `busy` is 0. `busy` is high from that edge until the result edge. `done` is a one-cycle pulse on the ninth edge after the start edge. `dout` and the flags are updated on that same edge and then held.
- R10: A `start` that arrives while `busy` is 1 is ignored. The running conversion finishes with its own operand and mode, and no extra `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture `din` and `mode` and begin a conversion |
| mode | input | 1 | 0: sign-magnitude to ten's complement; 1: ten's complement to sign-magnitude |
| din | input | 32 | Operand word |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| dout | output | 32 | Converted word, held until the next result |
| invalid | output | 1 | Operand had a bad digit or sign nibble |
| overflow | output | 1 | Magnitude did not fit in seven digits |

## Verification
A wrong borrow value shows up at the ports as a result digit that is off by one. That digit is at or above the position where the borrow went wrong, and the error is visible on the `done` pulse of the same conversion, nine cycles after start. A wrong digit counter or state shows as a `done` pulse that arrives early or late, or that lasts more than one cycle. A sign or validity flag captured at start and then corrupted shows in the final word as the wrong sign nibble, as a complemented rather than copied magnitude, or as a suppressed result. Each of these appears on the next result, so the directed scenarios pick operands where the borrow ripples across all eight digits, stops midway, or never starts.

// File: rtl/pdec_tc_conv.sv
module pdec_tc_conv #(
  parameter int DIGITS = 8,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] dout,
  output logic         invalid,
  output logic         overflow
);

  localparam int CW = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [3:0] SGN_POS = 4'hC;
  localparam logic [3:0] SGN_NEG = 4'hD;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t        state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  src_q, acc_q, dout_q;
  logic          neg_q, mode_q, bad_q, brw_q;
  logic          done_q, inv_q, ovf_q;

  // operand inspection at capture time
  logic [DIGITS-1:0] bad_nib;
  logic              in_bad, in_neg;
  logic [W-1:0]      in_src;

  always_comb begin
    for (int i = 0; i < DIGITS; i++) begin
      if (i == 0 && !mode) bad_nib[i] = din[4*i +: 4] < 4'hA;
      else                 bad_nib[i] = din[4*i +: 4] > 4'd9;
    end
  end

  assign in_bad = |bad_nib;
  assign in_neg = mode ? (din[W-1 -: 4] >= 4'd5)
                       : (din[3:0] == 4'hB || din[3:0] == 4'hD);
  assign in_src = mode ? din : {4'h0, din[W-1:4]};

  // one digit step with decimal borrow
  logic [3:0] dig, res_dig;
  logic [4:0] take;
  logic       brw_out;

  assign dig  = src_q[3:0];
  assign take = {1'b0, dig} + {4'b0, brw_q};

  always_comb begin
    if (!neg_q) begin
      res_dig = dig;
      brw_out = 1'b0;
    end else if (take == 5'd0) begin
      res_dig = 4'd0;
      brw_out = 1'b0;
    end else begin
      res_dig = 4'(5'd10 - take);
      brw_out = 1'b1;
    end
  end

  // result assembly
  logic [W-1:0] fin_word;
  logic         fin_ovf;

  always_comb begin
    if (mode_q) begin
      fin_word = {acc_q[W-5:0], neg_q ? SGN_NEG : SGN_POS};
      fin_ovf  = acc_q[W-1 -: 4] != 4'd0;
    end else begin
      fin_word = acc_q;
      fin_ovf  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      src_q   <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
      mode_q  <= 1'b0;
      bad_q   <= 1'b0;
      brw_q   <= 1'b0;
      dout_q  <= '0;
      done_q  <= 1'b0;
      inv_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_RUN;
          cnt_q   <= '0;
          src_q   <= in_src;
          acc_q   <= '0;
          neg_q   <= in_neg;
          mode_q  <= mode;
          bad_q   <= in_bad;
          brw_q   <= 1'b0;
        end
        S_RUN: begin
          acc_q <= {res_dig, acc_q[W-1:4]};
          src_q <= {4'h0, src_q[W-1:4]};
          brw_q <= brw_out;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(DIGITS - 1)) state_q <= S_FIN;
        end
        S_FIN: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          inv_q   <= bad_q;
          dout_q  <= bad_q ? '0 : fin_word;
          ovf_q   <= bad_q ? 1'b0 : fin_ovf;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = state_q != S_IDLE;
  assign done     = done_q;
  assign dout     = dout_q;
  assign invalid  = inv_q;
  assign overflow = ovf_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6
  sign_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q && !invalid) |-> (dout[3:0] == SGN_POS || dout[3:0] == SGN_NEG));

  // R8
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (dout == '0 && !overflow));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> mode_q);

endmodule

// File: tb/pdec_tc_conv_tb.sv
module pdec_tc_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] din = '0;
  logic        busy, done, invalid, overflow;
  logic [31:0] dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pdec_tc_conv u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
    .busy(busy), .done(done), .dout(dout), .invalid(invalid), .overflow(overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic m, input logic [31:0] x, output int lat);
    @(negedge clk);
    start = 1'b1; mode = m; din = x;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_conv(input string tag, input logic m, input logic [31:0] x,
                             input logic [31:0] y, input logic iv, input logic ov);
    int lat;
    convert(m, x, lat);
    check({tag, " dout"}, dout, y);
    check({tag, " invalid"}, {31'b0, invalid}, {31'b0, iv});
    check({tag, " overflow"}, {31'b0, overflow}, {31'b0, ov});
  endtask

  task automatic t_reset;
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 dout", dout, 32'd0);
    check("R1 flags", {30'b0, invalid, overflow}, 32'd0);
  endtask

  task automatic t_sm_positive;
    expect_conv("R2 127C", 1'b0, 32'h0000127C, 32'h00000127, 1'b0, 1'b0);
    expect_conv("R2 sign A", 1'b0, 32'h7654321A, 32'h07654321, 1'b0, 1'b0);
    expect_conv("R2 sign E", 1'b0, 32'h9999999E, 32'h09999999, 1'b0, 1'b0);
    expect_conv("R2 sign F", 1'b0, 32'h0000000F, 32'h00000000, 1'b0, 1'b0);
  endtask

  task automatic t_sm_negative;
    expect_conv("R3 1234567D", 1'b0, 32'h1234567D, 32'h98765433, 1'b0, 1'b0);
    expect_conv("R3 minus one B", 1'b0, 32'h0000001B, 32'h99999999, 1'b0, 1'b0);
    expect_conv("R3 max neg", 1'b0, 32'h9999999D, 32'h90000001, 1'b0, 1'b0);
    expect_conv("R3 mid", 1'b0, 32'h0005000D, 32'h99995000, 1'b0, 1'b0);
  endtask

  task automatic t_zero;
    expect_conv("R4 neg zero", 1'b0, 32'h0000000D, 32'h00000000, 1'b0, 1'b0);
    expect_conv("R4 tc zero", 1'b1, 32'h00000000, 32'h0000000C, 1'b0, 1'b0);
  endtask

  task automatic t_tc_to_sm;
    expect_conv("R5 pos", 1'b1, 32'h00000127, 32'h0000127C, 1'b0, 1'b0);
    expect_conv("R5 neg", 1'b1, 32'h98765433, 32'h1234567D, 1'b0, 1'b0);
    expect_conv("R5 minus one", 1'b1, 32'h99999999, 32'h0000001D, 1'b0, 1'b0);
    expect_conv("R5 max pos fit", 1'b1, 32'h09999999, 32'h9999999C, 1'b0, 1'b0);
    expect_conv("R5 max neg fit", 1'b1, 32'h90000001, 32'h9999999D, 1'b0, 1'b0);
  endtask

  task automatic t_normalize;
    int lat;
    convert(1'b0, 32'h0000042A, lat);
    check("R6 A to tc", dout, 32'h00000042);
    convert(1'b1, dout, lat);
    check("R6 back to C", dout, 32'h0000042C);
    convert(1'b0, 32'h0000042B, lat);
    convert(1'b1, dout, lat);
    check("R6 B back to D", dout, 32'h0000042D);
  endtask

  task automatic t_overflow;
    expect_conv("R7 pos big", 1'b1, 32'h12345678, 32'h2345678C, 1'b0, 1'b1);
    expect_conv("R7 most neg", 1'b1, 32'h50000000, 32'h0000000D, 1'b0, 1'b1);
    expect_conv("R7 neg big", 1'b1, 32'h89999999, 32'h0000001D, 1'b0, 1'b1);
    expect_conv("R7 most pos", 1'b1, 32'h49999999, 32'h9999999C, 1'b0, 1'b1);
  endtask

  task automatic t_invalid;
    expect_conv("R8 sign 9", 1'b0, 32'h12345679, 32'h00000000, 1'b1, 1'b0);
    expect_conv("R8 digit A sm", 1'b0, 32'h1A34567C, 32'h00000000, 1'b1, 1'b0);
    expect_conv("R8 low A tc", 1'b1, 32'h0000000A, 32'h00000000, 1'b1, 1'b0);
    expect_conv("R7 setup", 1'b1, 32'h12345678, 32'h2345678C, 1'b0, 1'b1);
    expect_conv("R8 masks overflow", 1'b1, 32'h1234567B, 32'h00000000, 1'b1, 1'b0);
  endtask

  task automatic t_timing;
    int lat;
    int busy_bad;
    @(negedge clk);
    start = 1'b1; mode = 1'b0; din = 32'h0000127C;
    @(negedge clk);
    start = 1'b0;
    busy_bad = 0;
    lat = 0;
    if (!busy) busy_bad++;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (!done && !busy) busy_bad++;
    end
    check("R9 latency", lat, 32'd9);
    check("R9 busy held", busy_bad, 32'd0);
    check("R9 busy clear at done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    check("R9 done one cycle", {31'b0, done}, 32'd0);
    check("R9 dout held", dout, 32'h00000127);
  endtask

  task automatic t_busy_ignore;
    int lat;
    int extra;
    @(negedge clk);
    start = 1'b1; mode = 1'b0; din = 32'h0000127C;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; mode = 1'b1; din = 32'h99999999;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R10 first operand kept", dout, 32'h00000127);
    extra = 0;
    repeat (15) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R10 no second done", extra, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sm_positive();
    t_sm_negative();
    t_zero();
    t_tc_to_sm();
    t_normalize();
    t_overflow();
    t_invalid();
    t_timing();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule